// File: doc/BRIEF.md
# Burst Beat Address Generator

This block follows the address phase of an AHB slave that serves local memory banks. It computes the byte address of every beat in a burst. The bus interface tells it when an address phase is accepted and passes on the transfer type, start address, transfer size and burst kind. On a new sequence the block captures the start address together with the burst controls. On each accepted sequential beat it steps the address, using an incrementing or a wrapping rule. Idle and busy beats leave the address unchanged.

The memory side reads the registered beat address and uses a final-beat flag to close fixed-length bursts. Both outputs are valid from the clock edge that accepted the address phase. Handshaking, the data path and the memories sit outside this block.

Top module: `ahb_burst_addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, the beat address is 0 and the final-beat flag is 0.
- R2: An accepted beat with transfer type NONSEQ (htrans 2'b10) makes the beat address equal to the presented address on the following cycle, and starts a new beat count.
- R3: In an incrementing burst, each accepted SEQ beat (htrans 2'b11) adds the transfer size in bytes to the address. hsize 0 adds 1 byte, hsize 1 adds 2 bytes and hsize 2 adds 4 bytes.
- R4: In a wrapping burst the address advances inside an aligned block whose size is the beat count multiplied by the transfer size. Address bits above that block never change. A 4-beat word wrap starting at 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: hburst is decoded as 000 single, 001 incrementing of undefined length, 010/011 wrap/increment of 4 beats, 100/101 wrap/increment of 8 beats, and 110/111 wrap/increment of 16 beats.
- R6: An incrementing step never carries out of its 1 KB page: address bits 10 and above stay fixed, and the low ten bits roll over to zero.
- R7: A BUSY beat (htrans 2'b01), an IDLE beat (2'b00) or a cycle whose beat is not accepted leaves the beat address and the final-beat flag unchanged.
- R8: The final-beat flag is 1 on the last beat of a fixed-length burst, including the only beat of a single transfer. It is never 1 in an undefined-length incrementing burst.
- R9: A SEQ beat accepted before any NONSEQ beat since reset is ignored.
- R10: A transfer size larger than the 32-bit bus (hsize above 2) is treated as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| accept_i | input | 1 | The address phase on the bus is accepted this cycle |
| htrans_i | input | 2 | Transfer type: 00 idle, 01 busy, 10 nonseq, 11 seq |
| haddr_i | input | ADDR_W | Presented byte address |
| hsize_i | input | 3 | log2 of the transfer size in bytes |
| hburst_i | input | 3 | Burst kind |
| beat_addr_o | output | ADDR_W | Byte address of the current beat |
| last_beat_o | output | 1 | Current beat ends a fixed-length burst |

## Verification
The assertions assume a master that keeps hsize and hburst constant across the sequential beats of a burst. They also assume it issues no SEQ beats past the length of a fixed burst, and that it starts a fresh NONSEQ before an undefined-length burst reaches a page edge. An assertion that checks only the page bits still tolerates the rollover. The stimulus respects these rules: every burst opens with a NONSEQ, controls are repeated unchanged on each SEQ, and fixed bursts stop at their beat count. Busy beats, unaccepted beats and a page-edge incrementing run are inserted inside these legal bursts.

// File: rtl/ahb_burst_pkg.sv
package ahb_burst_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'b000,
        BU_INCR   = 3'b001,
        BU_WRAP4  = 3'b010,
        BU_INCR4  = 3'b011,
        BU_WRAP8  = 3'b100,
        BU_INCR8  = 3'b101,
        BU_WRAP16 = 3'b110,
        BU_INCR16 = 3'b111
    } burst_e;

    typedef struct packed {
        logic       wrap;      // address wraps inside an aligned block
        logic       fixed;     // beat count is known
        logic [2:0] len_log2;  // log2 of beat count (0 for single / undefined)
    } burst_info_t;

endpackage

// File: rtl/burst_decode.sv
module burst_decode
    import ahb_burst_pkg::*;
(
    input  logic [2:0]  hburst_i,
    output burst_info_t info_o
);
    always_comb begin
        info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd0};
        case (burst_e'(hburst_i))
            BU_SINGLE: info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd0};
            BU_INCR:   info_o = '{wrap: 1'b0, fixed: 1'b0, len_log2: 3'd0};
            BU_WRAP4:  info_o = '{wrap: 1'b1, fixed: 1'b1, len_log2: 3'd2};
            BU_INCR4:  info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd2};
            BU_WRAP8:  info_o = '{wrap: 1'b1, fixed: 1'b1, len_log2: 3'd3};
            BU_INCR8:  info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd3};
            BU_WRAP16: info_o = '{wrap: 1'b1, fixed: 1'b1, len_log2: 3'd4};
            BU_INCR16: info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd4};
            default:   info_o = '{wrap: 1'b0, fixed: 1'b1, len_log2: 3'd0};
        endcase
    end
endmodule

// File: rtl/addr_step.sv
module addr_step #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_LOG2 = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              wrap_i,
    input  logic [2:0]        len_log2_i,
    output logic [ADDR_W-1:0] next_o,
    output logic [ADDR_W-1:0] mask_o
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = (ADDR_W'(1) << PAGE_LOG2) - ADDR_W'(1);

    logic [ADDR_W-1:0] bytes;
    logic [ADDR_W-1:0] wrap_mask;
    logic [ADDR_W-1:0] sum;
    logic [3:0]        span_log2;

    always_comb begin
        span_log2 = {1'b0, size_i} + {1'b0, len_log2_i};
        bytes     = ADDR_W'(1) << size_i;
        wrap_mask = (ADDR_W'(1) << span_log2) - ADDR_W'(1);
        mask_o    = wrap_i ? wrap_mask : PAGE_MASK;
        sum       = addr_i + bytes;
        next_o    = (addr_i & ~mask_o) | (sum & mask_o);
    end
endmodule

// File: rtl/ahb_burst_addr_gen.sv
module ahb_burst_addr_gen
    import ahb_burst_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int BUS_BYTES_LOG2 = 2,
    parameter int PAGE_LOG2      = 10,
    parameter int MAX_LEN_LOG2   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic [1:0]        htrans_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [2:0]        hsize_i,
    input  logic [2:0]        hburst_i,
    output logic [ADDR_W-1:0] beat_addr_o,
    output logic              last_beat_o
);
    localparam int CNT_W = MAX_LEN_LOG2 + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        burst_info_t       info;
        logic [CNT_W-1:0]  cnt;
        logic              last;
        logic              active;
    } state_t;

    state_t st_d, st_q;

    burst_info_t       dec_info;
    logic [2:0]        size_eff;
    logic [ADDR_W-1:0] step_next;
    logic [ADDR_W-1:0] step_mask;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  beats_m1;
    trans_e            trans;

    burst_decode u_decode (
        .hburst_i (hburst_i),
        .info_o   (dec_info)
    );

    addr_step #(
        .ADDR_W    (ADDR_W),
        .PAGE_LOG2 (PAGE_LOG2)
    ) u_step (
        .addr_i     (st_q.addr),
        .size_i     (st_q.size),
        .wrap_i     (st_q.info.wrap),
        .len_log2_i (st_q.info.len_log2),
        .next_o     (step_next),
        .mask_o     (step_mask)
    );

    always_comb begin
        trans    = trans_e'(htrans_i);
        size_eff = (hsize_i > 3'(BUS_BYTES_LOG2)) ? 3'(BUS_BYTES_LOG2) : hsize_i;
        cnt_inc  = st_q.cnt + CNT_W'(1);
        beats_m1 = (CNT_W'(1) << st_q.info.len_log2) - CNT_W'(1);
        st_d     = st_q;
        if (accept_i) begin
            case (trans)
                TR_NONSEQ: begin
                    st_d.addr   = haddr_i;
                    st_d.size   = size_eff;
                    st_d.info   = dec_info;
                    st_d.cnt    = '0;
                    st_d.last   = dec_info.fixed && (dec_info.len_log2 == 3'd0);
                    st_d.active = 1'b1;
                end
                TR_SEQ: begin
                    if (st_q.active) begin
                        st_d.addr = step_next;
                        st_d.cnt  = cnt_inc;
                        st_d.last = st_q.info.fixed && (cnt_inc == beats_m1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign beat_addr_o = st_q.addr;
    assign last_beat_o = st_q.last;

    // Assertions

    assert_nonseq_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b10) |=> (beat_addr_o == $past(haddr_i)));

    assert_wrap_upper_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b11 && st_q.active && st_q.info.wrap)
        |=> ((beat_addr_o & ~$past(step_mask)) == ($past(st_q.addr) & ~$past(step_mask))));

    assert_page_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b11 && st_q.active)
        |=> (beat_addr_o[ADDR_W-1:PAGE_LOG2] == $past(beat_addr_o[ADDR_W-1:PAGE_LOG2])));

    assert_hold_idle_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!accept_i || !htrans_i[1]) |=> ($stable(beat_addr_o) && $stable(last_beat_o)));

    assert_single_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b10 && hburst_i == 3'b000) |=> last_beat_o);

    assert_undef_never_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b10 && hburst_i == 3'b001) |=> !last_beat_o);

    assert_orphan_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept_i && htrans_i == 2'b11 && !st_q.active) |=> $stable(beat_addr_o));

endmodule

// File: tb/ahb_burst_addr_gen_tb.sv
module ahb_burst_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc;
    logic [1:0]  tr;
    logic [31:0] ad;
    logic [2:0]  sz;
    logic [2:0]  bu;
    logic [31:0] beat_addr;
    logic        last_beat;

    int total = 0;
    int bad   = 0;

    // reference model state
    logic [31:0] m_addr;
    int          m_size, m_beats, m_cnt;
    bit          m_wrap, m_fixed, m_last, m_active;

    always #5 clk = ~clk;

    ahb_burst_addr_gen u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .accept_i    (acc),
        .htrans_i    (tr),
        .haddr_i     (ad),
        .hsize_i     (sz),
        .hburst_i    (bu),
        .beat_addr_o (beat_addr),
        .last_beat_o (last_beat)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=0x%0h exp=0x%0h", tag, what, got, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] bytes, blk, base, page;
        if (!acc) return;
        if (tr == 2'b10) begin
            m_size = (sz > 3'd2) ? 2 : int'(sz);
            m_wrap = 0; m_fixed = 1; m_beats = 1;
            case (bu)
                3'b000: begin m_beats = 1;  end
                3'b001: begin m_fixed = 0;  end
                3'b010: begin m_beats = 4;  m_wrap = 1; end
                3'b011: begin m_beats = 4;  end
                3'b100: begin m_beats = 8;  m_wrap = 1; end
                3'b101: begin m_beats = 8;  end
                3'b110: begin m_beats = 16; m_wrap = 1; end
                default: begin m_beats = 16; end
            endcase
            m_addr = ad; m_cnt = 0; m_active = 1;
            m_last = m_fixed && (m_beats == 1);
        end else if (tr == 2'b11 && m_active) begin
            bytes = 32'd1 << m_size;
            if (m_wrap) begin
                blk  = bytes * m_beats;
                base = m_addr - (m_addr % blk);
                m_addr = base + ((m_addr - base + bytes) % blk);
            end else begin
                page = m_addr - (m_addr % 32'd1024);
                m_addr = page + (((m_addr % 32'd1024) + bytes) % 32'd1024);
            end
            m_cnt++;
            m_last = m_fixed && (m_cnt == m_beats - 1);
        end
    endtask

    task automatic beat(input logic [1:0] t, input logic [31:0] a, input logic [2:0] s,
                        input logic [2:0] b, input logic ac, input string tag);
        tr = t; ad = a; sz = s; bu = b; acc = ac;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, "addr", beat_addr, m_addr);
        chk(tag, "last", {31'd0, last_beat}, {31'd0, m_last});
    endtask

    task automatic nonseq(input logic [31:0] a, input logic [2:0] s, input logic [2:0] b, input string tag);
        beat(2'b10, a, s, b, 1'b1, tag);
    endtask

    task automatic seqs(input int n, input string tag);
        for (int i = 0; i < n; i++) beat(2'b11, m_addr, sz, bu, 1'b1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc = 1'b0; tr = 2'b00; ad = '0; sz = 3'd2; bu = 3'b000;
        m_addr = '0; m_size = 2; m_beats = 1; m_cnt = 0;
        m_wrap = 0; m_fixed = 1; m_last = 0; m_active = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "addr", beat_addr, 32'h0);
        chk("R1", "last", {31'd0, last_beat}, 32'h0);
        rst_n = 1'b1;

        // R9: sequential beat with no open burst
        beat(2'b11, 32'h0000_0AB0, 3'd2, 3'b011, 1'b1, "R9");
        chk("R9", "addr literal", beat_addr, 32'h0);

        // R2 R8: single transfer
        nonseq(32'h0000_0200, 3'd2, 3'b000, "R2 R8 R5 single");
        chk("R8", "single last literal", {31'd0, last_beat}, 32'h1);
        beat(2'b00, 32'h0000_0F00, 3'd2, 3'b000, 1'b1, "R7 idle");

        // R3: incrementing bursts of each size
        nonseq(32'h0000_0100, 3'd2, 3'b011, "R3 R5 incr4 word");
        seqs(3, "R3 R8 incr4 word");
        chk("R8", "incr4 last literal", {31'd0, last_beat}, 32'h1);
        chk("R3", "incr4 end literal", beat_addr, 32'h0000_010C);
        nonseq(32'h0000_000A, 3'd1, 3'b101, "R3 R5 incr8 half");
        seqs(7, "R3 R8 incr8 half");
        chk("R3", "incr8 end literal", beat_addr, 32'h0000_0018);
        nonseq(32'h0000_0005, 3'd0, 3'b111, "R3 R5 incr16 byte");
        seqs(15, "R3 R8 incr16 byte");
        chk("R3", "incr16 end literal", beat_addr, 32'h0000_0014);

        // R4: wrapping bursts
        nonseq(32'h0000_0034, 3'd2, 3'b010, "R4 R5 wrap4");
        chk("R4", "wrap4 b0", beat_addr, 32'h34);
        seqs(1, "R4"); chk("R4", "wrap4 b1", beat_addr, 32'h38);
        seqs(1, "R4"); chk("R4", "wrap4 b2", beat_addr, 32'h3C);
        seqs(1, "R4"); chk("R4", "wrap4 b3", beat_addr, 32'h30);
        chk("R8", "wrap4 last literal", {31'd0, last_beat}, 32'h1);
        nonseq(32'h0000_001E, 3'd1, 3'b100, "R4 R5 wrap8 half");
        seqs(1, "R4 wrap8 half"); chk("R4", "wrap8 half b1", beat_addr, 32'h10);
        seqs(6, "R4 R8 wrap8 half");
        nonseq(32'h0000_0847, 3'd0, 3'b110, "R4 R5 wrap16 byte");
        seqs(9, "R4 wrap16 byte"); chk("R4", "wrap16 b9", beat_addr, 32'h0840);
        seqs(6, "R4 R8 wrap16 byte");
        nonseq(32'h0000_007C, 3'd2, 3'b100, "R4 wrap8 word");
        seqs(7, "R4 R8 wrap8 word");

        // R6: undefined-length incrementing burst at a page edge
        nonseq(32'h0000_13F8, 3'd2, 3'b001, "R6 R5 incr undef");
        seqs(1, "R6"); chk("R6", "pre edge", beat_addr, 32'h13FC);
        seqs(1, "R6"); chk("R6", "rollover", beat_addr, 32'h1000);
        seqs(1, "R6 R8"); chk("R8", "undef never last", {31'd0, last_beat}, 32'h0);

        // R7: busy beats and unaccepted beats inside a burst
        nonseq(32'h0000_0300, 3'd2, 3'b011, "R7 incr4");
        seqs(1, "R7");
        beat(2'b01, 32'h0000_0308, 3'd2, 3'b011, 1'b1, "R7 busy");
        chk("R7", "busy hold literal", beat_addr, 32'h0304);
        beat(2'b01, 32'h0000_0308, 3'd2, 3'b011, 1'b1, "R7 busy2");
        beat(2'b11, 32'h0000_0308, 3'd2, 3'b011, 1'b0, "R7 not accepted");
        chk("R7", "stall hold literal", beat_addr, 32'h0304);
        seqs(2, "R7 R8");
        chk("R8", "last after busy", {31'd0, last_beat}, 32'h1);
        beat(2'b01, 32'h0, 3'd2, 3'b011, 1'b1, "R7 busy keeps last");

        // R10: oversize transfer
        nonseq(32'h0000_0400, 3'd3, 3'b011, "R10");
        beat(2'b11, 32'h0000_0404, 3'd3, 3'b011, 1'b1, "R10");
        chk("R10", "step literal", beat_addr, 32'h0404);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule